// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block draws a two-colour 32x32 sprite cursor over a scanned-out display. Software programs the cursor through a 32-bit register bus: a combined position word, thirty-two transparency rows and thirty-two colour rows, plus one general-purpose control word. During scan-out the display pipeline presents each pixel's coordinate together with the colour index already fetched for that pixel. One clock later the block returns either that index unchanged or one of two overlay palette slots that sit just above the normal index range.

The block also tells a downstream refresher which screen lines a cursor change has disturbed. Every update to the cursor's shape or placement produces a line span, so the refresher only has to redraw that band. A move produces two spans: the band the cursor is leaving and the band it is entering. Palette lookup, display timing and damage bookkeeping live outside the block.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor X and Y are both 0xF000, so no on-screen pixel is replaced, and no line span is reported until a cursor register is written.
- R2: A bus write to byte offset 0x8FC loads cursor X from data bits 31:16 and cursor Y from bits 15:0.
- R3: A write to byte offset 0x900 + 4*r (r = 0..31) loads transparency row r, and a write to 0x980 + 4*r loads colour row r.
- R4: The cursor covers screen lines Y to Y+31 and columns X to X+31; line Y+r uses row r, and column X+k uses bit 31-k of that row.
- R5: Where the transparency bit is 0, or the pixel is outside the cursor, the output index equals the input index; where it is 1, the output is slot 259 (2^IDX_W + 3) when the colour bit is 1 and slot 258 (2^IDX_W + 2) when it is 0.
- R6: Columns at or beyond the screen width SCREEN_W are never replaced, so a cursor at X >= SCREEN_W draws nothing.
- R7: The control word at byte offset 0x818 stores all 32 written bits and reads back with bit 25 forced to 1; a read of any other offset returns 0.
- R8: The output index and its valid flag appear exactly one clock after the pixel input, and the valid flag follows the input valid.
- R9: A write to a transparency or colour row reports, one clock later, a span with start = Y and end (exclusive) = min(SCREEN_H, Y+32).
- R10: A position write reports the span of the old Y one clock later and the span of the new Y on the clock after that.
- R11: A span whose Y is at or beyond SCREEN_H is not reported.
- R12: Writes to offsets other than the position, row and control words change neither the pixel output nor the span output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | DATA_W | Register read data, combinational from rd_addr |
| pix_valid | input | 1 | Pixel input valid |
| pix_x | input | COORD_W | Pixel column |
| pix_y | input | COORD_W | Pixel line |
| pix_idx | input | IDX_W | Underlying colour index |
| out_valid | output | 1 | Output pixel valid |
| out_idx | output | IDX_W+1 | Palette slot after overlay |
| dmg_valid | output | 1 | Line span pulse |
| dmg_start | output | COORD_W | First line of the span |
| dmg_end | output | COORD_W | Line after the last line of the span |

## Verification
The bench aims at the cursor's four edges: the first and last columns (bit 31 and bit 0) and the first and last rows, together with the column just outside each. A design that reversed the bit order or counted rows off by one would paint the wrong pixel or leave a hole there. Clipping is probed with the cursor straddling the screen width and the screen height, where a design without the width test would colour pixels beyond the visible line and a design without the height clamp would report a span past the last line. Moves are checked for both spans in order: a design that reported only the new band would leave a stale cursor image behind, and one that reported off-screen bands would be caught by the suppression check.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

   // Register byte offsets decoded by the block
   localparam logic [11:0] OFF_CTRL = 12'h818;
   localparam logic [11:0] OFF_POS  = 12'h8FC;
   localparam logic [11:0] OFF_MASK = 12'h900;
   localparam logic [11:0] OFF_IMG  = 12'h980;

   // Bit that always reads back as one in the control word
   localparam int CTRL_FIXED_BIT = 25;

   // Overlay slot offsets above the normal index range
   localparam int SLOT_CLEAR_OFS = 2;
   localparam int SLOT_SET_OFS   = 3;

   typedef enum logic [2:0] {
      WK_NONE,
      WK_POS,
      WK_MASK,
      WK_IMG,
      WK_CTRL
   } wr_kind_e;

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
   import cursor_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int COORD_W = 16,
   parameter int ROWS    = 32,
   parameter logic [COORD_W-1:0] PARK = 16'hF000
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   output logic [COORD_W-1:0]           cur_x,
   output logic [COORD_W-1:0]           cur_y,
   output logic [ROWS-1:0][DATA_W-1:0]  mask_rows,
   output logic [ROWS-1:0][DATA_W-1:0]  img_rows,
   output logic                         pos_wr,
   output logic                         row_wr
);

   localparam int ROW_W = $clog2(ROWS);
   localparam logic [ADDR_W-1:0] SPAN_BYTES = ADDR_W'(ROWS * 4);

   wr_kind_e          kind;
   logic [ADDR_W-1:0] mask_ofs, img_ofs;
   logic [ROW_W-1:0]  row_sel;
   logic [DATA_W-1:0] ctrl_q;

   always_comb begin
      mask_ofs = wr_addr - ADDR_W'(OFF_MASK);
      img_ofs  = wr_addr - ADDR_W'(OFF_IMG);
      kind     = WK_NONE;
      row_sel  = '0;
      if (wr_en) begin
         if (wr_addr == ADDR_W'(OFF_POS)) begin
            kind = WK_POS;
         end else if (wr_addr == ADDR_W'(OFF_CTRL)) begin
            kind = WK_CTRL;
         end else if (wr_addr >= ADDR_W'(OFF_MASK) && mask_ofs < SPAN_BYTES) begin
            kind    = WK_MASK;
            row_sel = mask_ofs[ROW_W+1:2];
         end else if (wr_addr >= ADDR_W'(OFF_IMG) && img_ofs < SPAN_BYTES) begin
            kind    = WK_IMG;
            row_sel = img_ofs[ROW_W+1:2];
         end
      end
   end

   assign pos_wr = (kind == WK_POS);
   assign row_wr = (kind == WK_MASK) || (kind == WK_IMG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_x  <= PARK;
         cur_y  <= PARK;
         ctrl_q <= '0;
      end else begin
         if (kind == WK_POS) begin
            cur_x <= wr_data[DATA_W-1 -: COORD_W];
            cur_y <= wr_data[COORD_W-1:0];
         end
         if (kind == WK_CTRL) begin
            ctrl_q <= wr_data;
         end
      end
   end

   // One storage word per cursor row for each plane
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_rows[r] <= '0;
            img_rows[r]  <= '0;
         end else if (row_sel == ROW_W'(r)) begin
            if (kind == WK_MASK) mask_rows[r] <= wr_data;
            if (kind == WK_IMG)  img_rows[r]  <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(OFF_CTRL)) begin
         rd_data = ctrl_q;
         rd_data[CTRL_FIXED_BIT] = 1'b1;
      end
   end

endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
   import cursor_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int COORD_W  = 16,
   parameter int IDX_W    = 8,
   parameter int ROWS     = 32,
   parameter int SCREEN_W = 1024
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pix_valid,
   input  logic [COORD_W-1:0]           pix_x,
   input  logic [COORD_W-1:0]           pix_y,
   input  logic [IDX_W-1:0]             pix_idx,
   input  logic [COORD_W-1:0]           cur_x,
   input  logic [COORD_W-1:0]           cur_y,
   input  logic [ROWS-1:0][DATA_W-1:0]  mask_rows,
   input  logic [ROWS-1:0][DATA_W-1:0]  img_rows,
   output logic                         out_valid,
   output logic [IDX_W:0]               out_idx
);

   localparam int ROW_W = $clog2(ROWS);
   localparam logic [IDX_W:0] SLOT_CLEAR = (IDX_W+1)'((1 << IDX_W) + SLOT_CLEAR_OFS);
   localparam logic [IDX_W:0] SLOT_SET   = (IDX_W+1)'((1 << IDX_W) + SLOT_SET_OFS);

   logic [COORD_W-1:0] dx, dy;
   logic               in_x, in_y;
   logic [ROW_W-1:0]   col, row;
   logic               m_bit, c_bit;
   logic [IDX_W:0]     nxt_idx;

   always_comb begin
      dx    = pix_x - cur_x;
      dy    = pix_y - cur_y;
      in_x  = (pix_x >= cur_x) && (dx < COORD_W'(ROWS)) && (pix_x < COORD_W'(SCREEN_W));
      in_y  = (pix_y >= cur_y) && (dy < COORD_W'(ROWS));
      row   = dy[ROW_W-1:0];
      col   = ROW_W'(ROWS - 1) - dx[ROW_W-1:0];
      m_bit = mask_rows[row][col];
      c_bit = img_rows[row][col];
      if (in_x && in_y && m_bit) begin
         nxt_idx = c_bit ? SLOT_SET : SLOT_CLEAR;
      end else begin
         nxt_idx = {1'b0, pix_idx};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_idx   <= '0;
      end else begin
         out_valid <= pix_valid;
         out_idx   <= nxt_idx;
      end
   end

endmodule

// File: rtl/cursor_damage.sv
module cursor_damage #(
   parameter int COORD_W  = 16,
   parameter int ROWS     = 32,
   parameter int SCREEN_H = 768
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pos_wr,
   input  logic               row_wr,
   input  logic [COORD_W-1:0] cur_y,
   output logic               dmg_valid,
   output logic [COORD_W-1:0] dmg_start,
   output logic [COORD_W-1:0] dmg_end
);

   localparam logic [COORD_W:0] H_EXT = (COORD_W+1)'(SCREEN_H);

   logic             move_pend;
   logic [COORD_W:0] y_ext, y_sum;

   always_comb begin
      y_ext = {1'b0, cur_y};
      y_sum = y_ext + (COORD_W+1)'(ROWS);
   end

   // cur_y still holds the pre-write value at the write edge, so the first
   // report of a move is the old band; move_pend brings out the new one.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         move_pend <= 1'b0;
         dmg_valid <= 1'b0;
         dmg_start <= '0;
         dmg_end   <= '0;
      end else begin
         move_pend <= pos_wr;
         dmg_valid <= (pos_wr || row_wr || move_pend) && (y_ext < H_EXT);
         dmg_start <= cur_y;
         dmg_end   <= (y_sum > H_EXT) ? H_EXT[COORD_W-1:0] : y_sum[COORD_W-1:0];
      end
   end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int COORD_W  = 16,
   parameter int IDX_W    = 8,
   parameter int SCREEN_W = 1024,
   parameter int SCREEN_H = 768
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               pix_valid,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [IDX_W-1:0]   pix_idx,
   output logic               out_valid,
   output logic [IDX_W:0]     out_idx,
   output logic               dmg_valid,
   output logic [COORD_W-1:0] dmg_start,
   output logic [COORD_W-1:0] dmg_end
);

   localparam int ROWS = DATA_W;

   if (ADDR_W < 12) begin : g_chk_addr
      $error("ADDR_W must reach the cursor register offsets");
   end
   if (2 * COORD_W != DATA_W) begin : g_chk_coord
      $error("position word must hold X and Y side by side");
   end
   if (SCREEN_W >= (1 << COORD_W) || SCREEN_H >= (1 << COORD_W)) begin : g_chk_screen
      $error("screen size must fit the coordinate width");
   end

   logic [COORD_W-1:0]          cur_x, cur_y;
   logic [ROWS-1:0][DATA_W-1:0] mask_rows, img_rows;
   logic                        pos_wr, row_wr;

   cursor_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COORD_W(COORD_W), .ROWS(ROWS),
      .PARK(COORD_W'(16'hF000))
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .cur_x(cur_x), .cur_y(cur_y),
      .mask_rows(mask_rows), .img_rows(img_rows),
      .pos_wr(pos_wr), .row_wr(row_wr)
   );

   cursor_hit #(
      .DATA_W(DATA_W), .COORD_W(COORD_W), .IDX_W(IDX_W), .ROWS(ROWS),
      .SCREEN_W(SCREEN_W)
   ) i_hit (
      .clk(clk), .rst_n(rst_n),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_idx(pix_idx),
      .cur_x(cur_x), .cur_y(cur_y),
      .mask_rows(mask_rows), .img_rows(img_rows),
      .out_valid(out_valid), .out_idx(out_idx)
   );

   cursor_damage #(
      .COORD_W(COORD_W), .ROWS(ROWS), .SCREEN_H(SCREEN_H)
   ) i_damage (
      .clk(clk), .rst_n(rst_n),
      .pos_wr(pos_wr), .row_wr(row_wr), .cur_y(cur_y),
      .dmg_valid(dmg_valid), .dmg_start(dmg_start), .dmg_end(dmg_end)
   );

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int COORD_W  = 16,
   parameter int IDX_W    = 8,
   parameter int SCREEN_H = 768
)(
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic [DATA_W-1:0]  rd_data,
   input logic               pix_valid,
   input logic [IDX_W-1:0]   pix_idx,
   input logic               out_valid,
   input logic [IDX_W:0]     out_idx,
   input logic               dmg_valid,
   input logic [COORD_W-1:0] dmg_start,
   input logic [COORD_W-1:0] dmg_end
);

   localparam logic [COORD_W-1:0] H_C  = COORD_W'(SCREEN_H);
   localparam logic [COORD_W-1:0] SPAN = COORD_W'(DATA_W);

   // R8: valid follows the input by one clock
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid);
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !out_valid);

   // R5: a non-overlay output is the delayed input index
   p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> (out_idx[IDX_W] || out_idx[IDX_W-1:0] == $past(pix_idx)));

   // R5: overlay outputs are only the two fixed slots
   p_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_idx[IDX_W]) |-> (out_idx[IDX_W-1:1] == (IDX_W)'(1)));

   // R11: spans lie on screen and are at most one cursor tall
   p_span_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dmg_valid |-> (dmg_start < H_C && dmg_end <= H_C && dmg_end > dmg_start
                     && (dmg_end - dmg_start) <= SPAN));

   // R9: no span without a write in the last two clocks
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !$past(wr_en)) |=> !dmg_valid);

   // R7: only the control offset reads non-zero, with the fixed bit set
   p_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(12'h818)) |-> rd_data[25]);
   p_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr != ADDR_W'(12'h818)) |-> (rd_data == '0));

   // R1: outputs idle on leaving reset
   p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !dmg_valid));

endmodule

bind cursor_overlay cursor_overlay_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COORD_W(COORD_W), .IDX_W(IDX_W),
   .SCREEN_H(SCREEN_H)
) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
   .rd_addr(rd_addr), .rd_data(rd_data),
   .pix_valid(pix_valid), .pix_idx(pix_idx),
   .out_valid(out_valid), .out_idx(out_idx),
   .dmg_valid(dmg_valid), .dmg_start(dmg_start), .dmg_end(dmg_end)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;

   localparam int W = 1024;
   localparam int H = 768;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [11:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic        pix_valid = 1'b0;
   logic [15:0] pix_x = '0, pix_y = '0;
   logic [7:0]  pix_idx = '0;
   logic        out_valid;
   logic [8:0]  out_idx;
   logic        dmg_valid;
   logic [15:0] dmg_start, dmg_end;

   int checks = 0;
   int errors = 0;

   // bench model of the programmed state
   int          cx = 16'hF000, cy = 16'hF000;
   logic [31:0] mask_m [32];
   logic [31:0] img_m  [32];
   logic [31:0] ctrl_m = '0;

   always #10 clk = ~clk;

   cursor_overlay i_cursor_overlay (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_idx(pix_idx),
      .out_valid(out_valid), .out_idx(out_idx),
      .dmg_valid(dmg_valid), .dmg_start(dmg_start), .dmg_end(dmg_end)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_pix(input int x, input int y, input int idx);
      int dx, dy;
      dx = x - cx;
      dy = y - cy;
      if (x < W && dx >= 0 && dx < 32 && dy >= 0 && dy < 32 && mask_m[dy][31-dx])
         return img_m[dy][31-dx] ? 259 : 258;
      return idx;
   endfunction

   task automatic chk_span(input bit ev, input int y, input string req);
      int ee;
      ee = (y + 32 > H) ? H : y + 32;
      chk(dmg_valid == ev, req, "span valid", dmg_valid, ev);
      if (ev && dmg_valid) begin
         chk(dmg_start == 16'(y), req, "span start", dmg_start, y);
         chk(dmg_end == 16'(ee), req, "span end", dmg_end, ee);
      end
   endtask

   // called at a falling edge; returns at a falling edge
   task automatic write_reg(input logic [11:0] a, input logic [31:0] d, input string req);
      int oy, kind;
      oy = cy;
      kind = 0;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      if (a == 12'h8FC) begin
         cx = d[31:16]; cy = d[15:0]; kind = 1;
      end else if (a >= 12'h900 && a < 12'h980) begin
         mask_m[(a - 12'h900) >> 2] = d; kind = 2;
      end else if (a >= 12'h980 && a < 12'hA00) begin
         img_m[(a - 12'h980) >> 2] = d; kind = 2;
      end else if (a == 12'h818) begin
         ctrl_m = d;
      end
      @(posedge clk); @(negedge clk);
      if (kind == 1)      chk_span(oy < H, oy, req);
      else if (kind == 2) chk_span(cy < H, cy, req);
      else                chk_span(1'b0, 0, req);
      wr_en = 1'b0;
      @(posedge clk); @(negedge clk);
      if (kind == 1) chk_span(cy < H, cy, req);
      else           chk_span(1'b0, 0, req);
   endtask

   task automatic pix(input int x, input int y, input int idx, input string req);
      int e;
      e = exp_pix(x, y, idx);
      pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_idx = 8'(idx);
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b1, req, "out_valid", out_valid, 1);
      chk(out_idx == 9'(e), req, "out_idx", out_idx, e);
      pix_valid = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string req);
      rd_addr = a;
      #2;
      chk(rd_data == e, req, "read data", rd_data, e);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_C0DE));
      for (int i = 0; i < 32; i++) begin
         mask_m[i] = '0;
         img_m[i]  = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: idle and parked after reset
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(dmg_valid == 1'b0, "R1", "dmg_valid after reset", dmg_valid, 0);
      pix(0, 0, 8'h3C, "R1");
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b0, "R8", "out_valid idle", out_valid, 0);

      // R7: control word readback
      rd(12'h818, 32'h0200_0000, "R7");
      write_reg(12'h818, 32'h0000_00A5, "R7");
      rd(12'h818, 32'h0200_00A5, "R7");
      rd(12'h8FC, 32'h0, "R7");
      rd(12'h900, 32'h0, "R7");

      // R3/R11: row writes while parked report no span
      write_reg(12'h900, 32'h8000_0001, "R11");
      write_reg(12'h980, 32'h8000_0000, "R3");
      write_reg(12'h914, 32'h0000_0100, "R3");
      write_reg(12'h994, 32'h0000_0100, "R3");
      write_reg(12'h97C, 32'hFFFF_FFFF, "R3");
      write_reg(12'h9FC, 32'h0000_0000, "R3");

      // R2/R10: move on screen, old band suppressed then new band
      write_reg(12'h8FC, 32'h0064_0032, "R10");
      pix(100, 50, 8'h11, "R4");
      pix(131, 50, 8'h12, "R4");
      pix(101, 50, 8'h13, "R5");
      pix(99,  50, 8'h14, "R4");
      pix(132, 50, 8'h15, "R4");
      pix(123, 55, 8'h16, "R3");
      pix(105, 81, 8'h17, "R4");
      pix(105, 82, 8'h18, "R4");
      pix(105, 49, 8'h19, "R4");
      pix(50, 100, 8'h1A, "R2");

      // R9: row write on screen reports the band
      write_reg(12'h904, 32'h4000_0000, "R9");
      pix(101, 51, 8'h1B, "R5");

      // R12: unmapped write changes nothing
      write_reg(12'h700, 32'hFFFF_FFFF, "R12");
      write_reg(12'h8F8, 32'hFFFF_FFFF, "R12");
      pix(100, 50, 8'h1C, "R12");
      pix(102, 50, 8'h1D, "R12");

      // R6/R11: clip against width and height
      write_reg(12'h900, 32'hFFFF_FFFF, "R6");
      write_reg(12'h980, 32'hFFFF_FFFF, "R6");
      write_reg(12'h8FC, {16'd1020, 16'd760}, "R10");
      pix(1023, 760, 8'h21, "R6");
      pix(1024, 760, 8'h22, "R6");
      write_reg(12'h8FC, {16'd1024, 16'd760}, "R6");
      pix(1024, 760, 8'h23, "R6");
      write_reg(12'h8FC, {16'd10, 16'd800}, "R11");
      write_reg(12'h8FC, {16'd10, 16'd767}, "R11");

      // random phase
      for (int it = 0; it < 40; it++) begin
         write_reg(12'h8FC, {16'($urandom_range(0, 1040)), 16'($urandom_range(0, 790))}, "R10");
         for (int k = 0; k < 4; k++) begin
            int r;
            r = $urandom_range(0, 31);
            write_reg(($urandom_range(0, 1) != 0) ? 12'(12'h900 + 4*r) : 12'(12'h980 + 4*r),
                      $urandom, "R9");
         end
         for (int k = 0; k < 20; k++) begin
            int x, y;
            x = cx + $urandom_range(0, 40) - 4;
            y = cy + $urandom_range(0, 40) - 4;
            if (x < 0) x = 0;
            if (y < 0) y = 0;
            pix(x, y, $urandom_range(0, 255), "R5");
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule